// File: doc/BRIEF.md
# Two-Tier Cache Line Error Protection Unit

This unit guards one 64-byte last-level cache line with a split error scheme. Every write into the line produces a cheap one-byte detection code that the cache keeps next to the data. When the written line is dirty, the unit also produces a strong correction record of eight bytes in the same cycle. That record leaves the unit for storage outside the cache array. Clean lines never produce such a record, because an intact copy of their data already exists further down the hierarchy.

On a read the unit recomputes the detection code and compares it with the stored one. A match returns the line unchanged. On a mismatch, a clean line is reported for refetch and nothing else happens. A dirty line instead raises a request for its correction record over a valid/ready handshake. The unit waits for the record, repairs every 8-byte word that it can, and reports the outcome. While a correction is in flight, no new read is taken.

Top module: `tiered_line_ecc`

## Requirements
- R1: Detection code bit i equals the XOR of bit i across all 64 bytes of the line. On a write, `wr_t1_code` shows it combinationally in the same cycle.
- R2: A write with `wr_dirty`=1 raises `t2_wr_valid` in the same cycle. Byte w of `t2_wr_code` is the check byte of data word w, where word w is bits [64w+63:64w]. That check byte is built as follows. The 64 data bits take, in ascending order, the codeword positions 1..71 that are not powers of two. Bit k, for k from 0 to 6, is the XOR of the data bits whose position has bit k set. Bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R3: A write with `wr_dirty`=0 leaves `t2_wr_valid` low.
- R4: An accepted read whose recomputed detection code equals `rd_t1_code` gives `res_valid` one cycle later. It has `res_kind`=0 (ok) and unchanged `res_data`, and no correction request is made.
- R5: An accepted clean read with a code mismatch gives `res_kind`=1 (refetch) one cycle later, and no correction request is made.
- R6: An accepted dirty read with a code mismatch raises `t2_req_valid` in the following cycle. The request stays high until `t2_req_ready` is seen.
- R7: From the acceptance of a dirty mismatching read until its correction record arrives, `rd_ready` and `res_valid` stay low.
- R8: If no word shows a double error, the result is `res_kind`=2 (corrected). Each word with a single flipped data bit comes back repaired. A fault only in the stored detection byte returns the data unchanged.
- R9: If any word shows two flipped bits, the result is `res_kind`=3 (uncorrectable).
- R10: `res_valid` is a one-cycle pulse. It rises the cycle after the `t2_rsp_valid`/`t2_rsp_ready` handshake and the unit then accepts reads again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Line write or fill presented |
| wr_dirty | input | 1 | Written line is dirty |
| wr_data | input | 512 | Line data to write |
| wr_t1_code | output | 8 | Detection code for the written line |
| t2_wr_valid | output | 1 | Correction record emitted for storage |
| t2_wr_code | output | 64 | Correction record, one check byte per word |
| rd_valid | input | 1 | Line read presented |
| rd_ready | output | 1 | Unit can accept a read |
| rd_dirty | input | 1 | Read line is dirty |
| rd_data | input | 512 | Line data read from the array |
| rd_t1_code | input | 8 | Stored detection code of the read line |
| t2_req_valid | output | 1 | Request for the line's correction record |
| t2_req_ready | input | 1 | Request taken |
| t2_rsp_valid | input | 1 | Correction record returned |
| t2_rsp_ready | output | 1 | Unit waiting for the record |
| t2_rsp_code | input | 64 | Returned correction record |
| res_valid | output | 1 | Read result pulse |
| res_kind | output | 2 | 0 ok, 1 refetch, 2 corrected, 3 uncorrectable |
| res_data | output | 512 | Read result data |

## Verification
The bench builds the unit with its default of eight 64-bit words. With that setting, single faults can be placed in the first and last words and in different bit columns of the detection code. Double faults are confined to one word, so the word-level decision is tested. Faults confined to the stored detection byte exercise the case where no data bit is bad. The bench holds back the request and response handshakes for extra cycles, which makes the stall and hold behaviour observable at the ports.

// File: rtl/tlecc_pkg.sv
package tlecc_pkg;

  localparam int WORD_W = 64;
  localparam int CHK_W  = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    K_OK      = 2'd0,
    K_REFETCH = 2'd1,
    K_FIXED   = 2'd2,
    K_UNCORR  = 2'd3
  } kind_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              dbl;
  } fix_t;

  // Hamming check bits 0..6 plus overall parity in bit 7.
  function automatic logic [CHK_W-1:0] secded_check(input logic [WORD_W-1:0] d);
    logic [6:0] h;
    int         j;
    h = '0;
    j = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[j]) h = h ^ 7'(p);
        j++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  function automatic fix_t secded_fix(input logic [WORD_W-1:0] d,
                                      input logic [CHK_W-1:0]  rcv);
    fix_t       r;
    logic [7:0] calc;
    logic [6:0] syn;
    logic       ov;
    int         j;
    calc = secded_check(d);
    syn  = calc[6:0] ^ rcv[6:0];
    ov   = (^d) ^ (^rcv);
    r.data = d;
    j = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (ov && (7'(p) == syn)) r.data[j] = ~d[j];
        j++;
      end
    end
    r.dbl = ((syn != 7'd0) && !ov) || (ov && (syn > 7'd71));
    return r;
  endfunction

endpackage

// File: rtl/tlecc_t1_gen.sv
module tlecc_t1_gen #(
  parameter int NUM_BYTES = 64
) (
  input  logic [NUM_BYTES*8-1:0] line,
  output logic [7:0]             code
);
  always_comb begin
    code = '0;
    for (int b = 0; b < NUM_BYTES; b++) code = code ^ line[b*8 +: 8];
  end
endmodule

// File: rtl/tlecc_t2_enc.sv
module tlecc_t2_enc #(
  parameter int NUM_WORDS = 8
) (
  input  logic [NUM_WORDS*tlecc_pkg::WORD_W-1:0] line,
  output logic [NUM_WORDS*tlecc_pkg::CHK_W-1:0]  code
);
  localparam int WW = tlecc_pkg::WORD_W;
  localparam int CW = tlecc_pkg::CHK_W;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign code[w*CW +: CW] = tlecc_pkg::secded_check(line[w*WW +: WW]);
  end
endmodule

// File: rtl/tlecc_t2_fix.sv
module tlecc_t2_fix #(
  parameter int NUM_WORDS = 8
) (
  input  logic [NUM_WORDS*tlecc_pkg::WORD_W-1:0] line,
  input  logic [NUM_WORDS*tlecc_pkg::CHK_W-1:0]  code,
  output logic [NUM_WORDS*tlecc_pkg::WORD_W-1:0] fixed,
  output logic                                   any_dbl
);
  localparam int WW = tlecc_pkg::WORD_W;
  localparam int CW = tlecc_pkg::CHK_W;

  logic [NUM_WORDS-1:0] dbl_w;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    tlecc_pkg::fix_t r;
    assign r                  = tlecc_pkg::secded_fix(line[w*WW +: WW], code[w*CW +: CW]);
    assign fixed[w*WW +: WW]  = r.data;
    assign dbl_w[w]           = r.dbl;
  end

  assign any_dbl = |dbl_w;
endmodule

// File: rtl/tiered_line_ecc.sv
module tiered_line_ecc #(
  parameter int NUM_WORDS = 8,
  localparam int LINE_W   = NUM_WORDS * tlecc_pkg::WORD_W,
  localparam int T2_W     = NUM_WORDS * tlecc_pkg::CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [LINE_W-1:0] wr_data,
  output logic [7:0]        wr_t1_code,
  output logic              t2_wr_valid,
  output logic [T2_W-1:0]   t2_wr_code,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic              rd_dirty,
  input  logic [LINE_W-1:0] rd_data,
  input  logic [7:0]        rd_t1_code,
  output logic              t2_req_valid,
  input  logic              t2_req_ready,
  input  logic              t2_rsp_valid,
  output logic              t2_rsp_ready,
  input  logic [T2_W-1:0]   t2_rsp_code,
  output logic              res_valid,
  output logic [1:0]        res_kind,
  output logic [LINE_W-1:0] res_data
);
  import tlecc_pkg::*;

  localparam int NUM_BYTES = LINE_W / 8;

  // Write side: both codes ready in the acceptance cycle.
  tlecc_t1_gen #(.NUM_BYTES(NUM_BYTES)) u_t1_wr (.line(wr_data), .code(wr_t1_code));
  tlecc_t2_enc #(.NUM_WORDS(NUM_WORDS)) u_t2_enc (.line(wr_data), .code(t2_wr_code));
  assign t2_wr_valid = wr_valid & wr_dirty;

  // Read side.
  logic [7:0]        rd_t1_calc;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] fixed_line;
  logic              fix_dbl;
  state_e            state_q;
  kind_e             kind_q;
  logic              res_valid_q;

  tlecc_t1_gen #(.NUM_BYTES(NUM_BYTES)) u_t1_rd (.line(rd_data), .code(rd_t1_calc));
  tlecc_t2_fix #(.NUM_WORDS(NUM_WORDS)) u_t2_fix (
    .line    (line_q),
    .code    (t2_rsp_code),
    .fixed   (fixed_line),
    .any_dbl (fix_dbl)
  );

  // Named events for the checker.
  logic rd_accept;
  logic t1_mismatch;
  logic rsp_take;
  assign rd_ready     = (state_q == ST_IDLE);
  assign rd_accept    = rd_valid & rd_ready;
  assign t1_mismatch  = (rd_t1_calc != rd_t1_code);
  assign t2_req_valid = (state_q == ST_REQ);
  assign t2_rsp_ready = (state_q == ST_WAIT);
  assign rsp_take     = t2_rsp_valid & t2_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= K_OK;
      res_valid_q <= 1'b0;
      line_q      <= '0;
    end else begin
      res_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (rd_accept) begin
            line_q <= rd_data;
            if (!t1_mismatch) begin
              res_valid_q <= 1'b1;
              kind_q      <= K_OK;
            end else if (!rd_dirty) begin
              res_valid_q <= 1'b1;
              kind_q      <= K_REFETCH;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (t2_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_take) begin
            line_q      <= fixed_line;
            res_valid_q <= 1'b1;
            kind_q      <= fix_dbl ? K_UNCORR : K_FIXED;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign res_valid = res_valid_q;
  assign res_kind  = kind_q;
  assign res_data  = line_q;

endmodule

// File: rtl/tlecc_chk.sv
module tlecc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_accept,
  input logic       t1_mismatch,
  input logic       rd_dirty,
  input logic       rd_ready,
  input logic       t2_req_valid,
  input logic       t2_req_ready,
  input logic       t2_rsp_ready,
  input logic       rsp_take,
  input logic       res_valid,
  input logic [1:0] res_kind
);
  // R4
  a_r4_ok_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept && !t1_mismatch |=> res_valid && (res_kind == 2'd0) && !t2_req_valid);
  // R5
  a_r5_refetch_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept && t1_mismatch && !rd_dirty |=> res_valid && (res_kind == 2'd1) && !t2_req_valid);
  // R6
  a_r6_req_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept && t1_mismatch && rd_dirty |=> t2_req_valid);
  // R6
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    t2_req_valid && !t2_req_ready |=> t2_req_valid);
  // R7
  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_req_valid || t2_rsp_ready) |-> !rd_ready && !res_valid);
  // R10
  a_r10_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> res_valid && res_kind[1] && rd_ready);
  // R10
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid || $past(rd_accept));
endmodule

bind tiered_line_ecc tlecc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_accept    (rd_accept),
  .t1_mismatch  (t1_mismatch),
  .rd_dirty     (rd_dirty),
  .rd_ready     (rd_ready),
  .t2_req_valid (t2_req_valid),
  .t2_req_ready (t2_req_ready),
  .t2_rsp_ready (t2_rsp_ready),
  .rsp_take     (rsp_take),
  .res_valid    (res_valid),
  .res_kind     (res_kind)
);

// File: tb/tiered_line_ecc_tb_top.sv
`timescale 1ns/1ps
module tiered_line_ecc_tb_top;
  localparam int LW = 512;
  localparam int TW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, wr_dirty = 1'b0;
  logic [LW-1:0] wr_data = '0;
  logic [7:0]    wr_t1_code;
  logic          t2_wr_valid;
  logic [TW-1:0] t2_wr_code;
  logic          rd_valid = 1'b0, rd_ready, rd_dirty = 1'b0;
  logic [LW-1:0] rd_data = '0;
  logic [7:0]    rd_t1_code = '0;
  logic          t2_req_valid, t2_req_ready = 1'b0;
  logic          t2_rsp_valid = 1'b0, t2_rsp_ready;
  logic [TW-1:0] t2_rsp_code = '0;
  logic          res_valid;
  logic [1:0]    res_kind;
  logic [LW-1:0] res_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  tiered_line_ecc dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference detection byte: fold every byte.
  function automatic logic [7:0] ref_t1(input logic [LW-1:0] l);
    logic [7:0] c = '0;
    for (int b = 0; b < LW/8; b++) c ^= l[b*8 +: 8];
    return c;
  endfunction

  // Reference check byte: place bits in a codeword, then fold by position bit.
  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [127:0] cw = '0;
    logic [7:0]   c = '0;
    int           j = 0;
    for (int p = 1; p < 72; p++)
      if ($countones(p) != 1) begin cw[p] = d[j]; j++; end
    for (int k = 0; k < 7; k++)
      for (int p = 1; p < 72; p++)
        if (((p >> k) & 1) == 1) c[k] ^= cw[p];
    c[7] = ^{d, c[6:0]};
    return c;
  endfunction

  function automatic logic [TW-1:0] ref_t2(input logic [LW-1:0] l);
    logic [TW-1:0] r;
    for (int w = 0; w < 8; w++) r[w*8 +: 8] = ref_chk(l[w*64 +: 64]);
    return r;
  endfunction

  function automatic logic [LW-1:0] mk_line(input logic [31:0] seed);
    logic [LW-1:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = seed * (i + 7) ^ (32'h9E3779B1 * i);
    return l;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(rd_ready == 1'b1, "R7 reset rd_ready", LW'(rd_ready), 1);
    chk(res_valid == 1'b0, "R10 reset res_valid", LW'(res_valid), 0);
    chk(t2_req_valid == 1'b0, "R6 reset req", LW'(t2_req_valid), 0);
  endtask

  task automatic t_write(input logic [LW-1:0] d, input bit dirty);
    @(negedge clk);
    wr_valid = 1'b1; wr_dirty = dirty; wr_data = d;
    #1;
    chk(wr_t1_code == ref_t1(d), "R1 write t1", LW'(wr_t1_code), LW'(ref_t1(d)));
    if (dirty) begin
      chk(t2_wr_valid == 1'b1, "R2 t2 valid", LW'(t2_wr_valid), 1);
      chk(t2_wr_code == ref_t2(d), "R2 t2 code", LW'(t2_wr_code), LW'(ref_t2(d)));
    end else
      chk(t2_wr_valid == 1'b0, "R3 clean no t2", LW'(t2_wr_valid), 0);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Read a line; on the correction path the handshakes are stretched.
  task automatic t_read(input logic [LW-1:0] d, input logic [7:0] t1, input bit dirty,
                        input logic [TW-1:0] rsp, input bit want_req,
                        input logic [1:0] kind, input logic [LW-1:0] exp, input string req);
    @(negedge clk);
    chk(rd_ready == 1'b1, {req, " ready"}, LW'(rd_ready), 1);
    rd_valid = 1'b1; rd_dirty = dirty; rd_data = d; rd_t1_code = t1;
    @(negedge clk);
    rd_valid = 1'b0;
    if (want_req) begin
      chk(t2_req_valid == 1'b1, "R6 req raised", LW'(t2_req_valid), 1);
      chk(rd_ready == 1'b0 && res_valid == 1'b0, "R7 stall in req", LW'({rd_ready, res_valid}), 0);
      @(negedge clk);
      chk(t2_req_valid == 1'b1, "R6 req held", LW'(t2_req_valid), 1);
      t2_req_ready = 1'b1;
      @(negedge clk);
      t2_req_ready = 1'b0;
      chk(t2_req_valid == 1'b0 && t2_rsp_ready == 1'b1, "R6 req taken", LW'({t2_req_valid, t2_rsp_ready}), 1);
      @(negedge clk);
      chk(rd_ready == 1'b0 && res_valid == 1'b0, "R7 stall in wait", LW'({rd_ready, res_valid}), 0);
      t2_rsp_valid = 1'b1; t2_rsp_code = rsp;
      @(negedge clk);
      t2_rsp_valid = 1'b0;
      chk(rd_ready == 1'b1, "R10 ready after rsp", LW'(rd_ready), 1);
    end else
      chk(t2_req_valid == 1'b0, {req, " no req"}, LW'(t2_req_valid), 0);
    chk(res_valid == 1'b1, {req, " res_valid"}, LW'(res_valid), 1);
    chk(res_kind == kind, {req, " kind"}, LW'(res_kind), LW'(kind));
    chk(res_data == exp, {req, " data"}, res_data, exp);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 pulse ends", LW'(res_valid), 0);
  endtask

  initial begin
    logic [LW-1:0] a, b, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();

    a = mk_line(32'h1234_5677);
    b = mk_line(32'hCAFE_0001);
    t_write(a, 1'b1);
    t_write(b, 1'b1);
    t_write({64{8'hA5}}, 1'b1);
    t_write('0, 1'b1);
    t_write(b, 1'b0);

    t_read(a, ref_t1(a), 1'b0, '0, 0, 2'd0, a, "R4 clean ok");
    t_read(b, ref_t1(b), 1'b1, '0, 0, 2'd0, b, "R4 dirty ok");

    bad = a; bad[300] = ~bad[300];
    t_read(bad, ref_t1(a), 1'b0, '0, 0, 2'd1, bad, "R5 refetch");

    bad = b; bad[5] = ~bad[5]; bad[6*64+40] = ~bad[6*64+40];
    t_read(bad, ref_t1(b), 1'b1, ref_t2(b), 1, 2'd2, b, "R8 two words fixed");

    bad = a; bad[7*64+63] = ~bad[7*64+63];
    t_read(bad, ref_t1(a), 1'b1, ref_t2(a), 1, 2'd2, a, "R8 last bit fixed");

    t_read(b, ref_t1(b) ^ 8'h10, 1'b1, ref_t2(b), 1, 2'd2, b, "R8 t1 byte fault");

    bad = a; bad[2*64+0] = ~bad[2*64+0]; bad[2*64+9] = ~bad[2*64+9];
    t_read(bad, ref_t1(a), 1'b1, ref_t2(a), 1, 2'd3, bad, "R9 double");

    t_read(a, ref_t1(a), 1'b0, '0, 0, 2'd0, a, "R10 accepts again");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule